// File: doc/BRIEF.md
# Unified Polar SC Processing Element

This block is one processing element of a successive-cancellation polar decoder. On each accepted input it forms either the min-sum f update or the partial-sum-steered g update from two log-likelihood ratios. The result goes to the next decoder stage. The decoder tree, the scheduling, the partial-sum generation and the final decision logic sit outside it and drive its inputs.

LLRs enter and leave in sign-magnitude form. The sign bit is at position MAG_W, where 1 means negative. The magnitude sits in bits MAG_W-1 down to 0, and MAG_W defaults to 5. For the g path both inputs are widened into two's complement. One adder and one subtractor both work on them, and the chosen result is clipped and turned back into sign-magnitude. The f path takes the smaller magnitude and the XOR of the signs. A select input picks which of the two reaches the single output register.

Top module: `polar_sc_pe`

## Requirements
- R1: While `rst` is high at a rising edge, the next state of `out_llr` is 0 and the next state of `out_vld` is 0.
- R2: With `sel_g` = 0 (f mode), the output sign is sign(a) XOR sign(b) and the output magnitude is min(|a|, |b|).
- R3: With `sel_g` = 1 (g mode), the output is b + a when `psum` = 0 and b − a when `psum` = 1, where a is `llr_a` and b is `llr_b`.
- R4: A g result above 2^MAG_W − 1 is emitted as +(2^MAG_W − 1), and one below −(2^MAG_W − 1) as −(2^MAG_W − 1). The result never wraps.
- R5: An input with sign 1 and magnitude 0 behaves exactly as +0 in both modes.
- R6: A zero result is always emitted with sign bit 0.
- R7: A result is presented one clock after its inputs are sampled with `in_vld` = 1, and `out_vld` equals `in_vld` delayed by one clock.
- R8: When `in_vld` is 0 at an edge, `out_llr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Inputs are valid this cycle |
| sel_g | input | 1 | 0 selects the f update, 1 selects the g update |
| psum | input | 1 | Partial-sum bit for g: 0 adds, 1 subtracts |
| llr_a | input | MAG_W+1 | First LLR a, sign-magnitude |
| llr_b | input | MAG_W+1 | Second LLR b, sign-magnitude |
| out_vld | output | 1 | Output LLR is valid |
| out_llr | output | MAG_W+1 | Result LLR, sign-magnitude |

## Verification
Both updates pass through a single output register, so every result and its valid flag are due exactly one rising edge after the inputs are sampled. The bench drives inputs on the falling edge. It samples the outputs on the next falling edge, after that one rising edge and away from any active edge. Cycles with `in_vld` low are checked on that same falling edge against the value held from the last accepted input. Reset is checked one falling edge after the rising edge that sampled it high.

// File: rtl/polar_pe_pkg.sv
package polar_pe_pkg;
  localparam int PE_MAG_W_DEF = 5;

  typedef enum logic {
    PE_SEL_F = 1'b0,
    PE_SEL_G = 1'b1
  } pe_sel_e;

  function automatic int pe_mag_max(input int mag_w);
    return (1 << mag_w) - 1;
  endfunction
endpackage

// File: rtl/polar_pe_sm2tc.sv
module polar_pe_sm2tc #(
  parameter int MAG_W = polar_pe_pkg::PE_MAG_W_DEF
) (
  input  logic [MAG_W:0]          sm_i,
  output logic signed [MAG_W+1:0] tc_o
);
  logic signed [MAG_W+1:0] mag_ext;

  assign mag_ext = $signed({2'b00, sm_i[MAG_W-1:0]});
  // negative zero maps to 0 because -0 == 0 in two's complement
  assign tc_o    = sm_i[MAG_W] ? -mag_ext : mag_ext;
endmodule

// File: rtl/polar_pe_tc2sm.sv
module polar_pe_tc2sm #(
  parameter int MAG_W = polar_pe_pkg::PE_MAG_W_DEF
) (
  input  logic signed [MAG_W+1:0] tc_i,
  output logic [MAG_W:0]          sm_o
);
  localparam int TC_W = MAG_W + 2;
  localparam logic signed [TC_W-1:0] POS_LIM = TC_W'(polar_pe_pkg::pe_mag_max(MAG_W));
  localparam logic signed [TC_W-1:0] NEG_LIM = -POS_LIM;

  logic signed [TC_W-1:0] abs_v;

  always_comb begin
    abs_v = (tc_i < 0) ? -tc_i : tc_i;
    if (tc_i > POS_LIM) begin
      sm_o = {1'b0, POS_LIM[MAG_W-1:0]};
    end else if (tc_i < NEG_LIM) begin
      sm_o = {1'b1, POS_LIM[MAG_W-1:0]};
    end else begin
      sm_o = {(tc_i < 0), abs_v[MAG_W-1:0]};
    end
  end

  // R4 / R6: an in-range value is carried through exactly, zero is positive
  always_comb begin
    if (tc_i <= POS_LIM && tc_i >= NEG_LIM) begin
      a_inrange_exact_r4: assert (
        (sm_o[MAG_W] ? -$signed({2'b00, sm_o[MAG_W-1:0]})
                     :  $signed({2'b00, sm_o[MAG_W-1:0]})) == tc_i);
    end
    a_zero_positive_r6: assert (!(sm_o[MAG_W] && sm_o[MAG_W-1:0] == '0));
  end
endmodule

// File: rtl/polar_pe_fmin.sv
module polar_pe_fmin #(
  parameter int MAG_W = polar_pe_pkg::PE_MAG_W_DEF
) (
  input  logic [MAG_W:0] a_i,
  input  logic [MAG_W:0] b_i,
  output logic [MAG_W:0] f_o
);
  logic [MAG_W-1:0] mag_a, mag_b, mag_min;
  logic             sgn;

  always_comb begin
    mag_a   = a_i[MAG_W-1:0];
    mag_b   = b_i[MAG_W-1:0];
    mag_min = (mag_a < mag_b) ? mag_a : mag_b;
    sgn     = (a_i[MAG_W] ^ b_i[MAG_W]) && (mag_min != '0);
    f_o     = {sgn, mag_min};
  end

  // R2: result magnitude never exceeds either input magnitude
  always_comb begin
    a_f_min_r2: assert (f_o[MAG_W-1:0] <= mag_a && f_o[MAG_W-1:0] <= mag_b);
  end
endmodule

// File: rtl/polar_sc_pe.sv
module polar_sc_pe #(
  parameter int MAG_W = polar_pe_pkg::PE_MAG_W_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_vld,
  input  logic           sel_g,
  input  logic           psum,
  input  logic [MAG_W:0] llr_a,
  input  logic [MAG_W:0] llr_b,
  output logic           out_vld,
  output logic [MAG_W:0] out_llr
);
  import polar_pe_pkg::*;

  localparam int SM_W = MAG_W + 1;
  localparam int TC_W = MAG_W + 2;
  localparam int N_IN = 2;

  logic [SM_W-1:0]        in_sm [N_IN];
  logic signed [TC_W-1:0] in_tc [N_IN];
  logic signed [TC_W-1:0] g_sum, g_dif, g_tc;
  logic [SM_W-1:0]        g_sm, f_sm, nxt_llr;
  pe_sel_e                sel;

  assign in_sm[0] = llr_a;
  assign in_sm[1] = llr_b;
  assign sel      = pe_sel_e'(sel_g);

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_conv_in
    polar_pe_sm2tc #(.MAG_W(MAG_W)) u_sm2tc (
      .sm_i (in_sm[gi]),
      .tc_o (in_tc[gi])
    );
  end

  // g path: adder and subtractor both run, partial sum picks one
  assign g_sum = in_tc[1] + in_tc[0];
  assign g_dif = in_tc[1] - in_tc[0];
  assign g_tc  = psum ? g_dif : g_sum;

  polar_pe_tc2sm #(.MAG_W(MAG_W)) u_tc2sm (
    .tc_i (g_tc),
    .sm_o (g_sm)
  );

  polar_pe_fmin #(.MAG_W(MAG_W)) u_fmin (
    .a_i (llr_a),
    .b_i (llr_b),
    .f_o (f_sm)
  );

  assign nxt_llr = (sel == PE_SEL_G) ? g_sm : f_sm;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_llr <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_llr <= nxt_llr;
      end
    end
  end

  p_vld_rise_r7: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);
  p_vld_fall_r7: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(out_llr));
  p_pos_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !(out_llr[MAG_W] && out_llr[MAG_W-1:0] == '0));
  p_f_sign_r2: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !sel_g && llr_a[MAG_W-1:0] != '0 && llr_b[MAG_W-1:0] != '0)
      |=> (out_llr[MAG_W] == ($past(llr_a[MAG_W]) ^ $past(llr_b[MAG_W]))));
endmodule

// File: tb/tb_polar_sc_pe.sv
module tb_polar_sc_pe;
  localparam int MAG_W   = 5;
  localparam int MAXM    = (1 << MAG_W) - 1;
  localparam int CLK_PER = 10;
  localparam int WDOG    = 100000;

  logic           clk = 1'b0;
  logic           rst, in_vld, sel_g, psum;
  logic [MAG_W:0] llr_a, llr_b;
  logic           out_vld;
  logic [MAG_W:0] out_llr;

  int errors = 0;
  int checks = 0;
  logic [MAG_W:0] exp_llr;

  always #(CLK_PER/2) clk = ~clk;

  polar_sc_pe #(.MAG_W(MAG_W)) dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .sel_g(sel_g), .psum(psum),
    .llr_a(llr_a), .llr_b(llr_b), .out_vld(out_vld), .out_llr(out_llr)
  );

  function automatic int to_int(input logic [MAG_W:0] x);
    int m = int'(x[MAG_W-1:0]);
    return x[MAG_W] ? -m : m;
  endfunction

  function automatic logic [MAG_W:0] to_sm(input int v);
    int c = (v > MAXM) ? MAXM : ((v < -MAXM) ? -MAXM : v);
    if (c < 0) return {1'b1, MAG_W'(-c)};
    return {1'b0, MAG_W'(c)};
  endfunction

  function automatic logic [MAG_W:0] model(input logic g, input logic p,
                                           input logic [MAG_W:0] a,
                                           input logic [MAG_W:0] b);
    int ma, mb, m;
    if (!g) begin
      ma = int'(a[MAG_W-1:0]);
      mb = int'(b[MAG_W-1:0]);
      m  = (ma < mb) ? ma : mb;
      return (m == 0) ? '0 : {a[MAG_W] ^ b[MAG_W], MAG_W'(m)};
    end
    return p ? to_sm(to_int(b) - to_int(a)) : to_sm(to_int(b) + to_int(a));
  endfunction

  task automatic check(input string tag, input logic [MAG_W:0] e_llr, input logic e_vld);
    checks++;
    if (out_llr !== e_llr || out_vld !== e_vld) begin
      errors++;
      $display("FAIL %s: out_llr=%b out_vld=%b expected out_llr=%b out_vld=%b",
               tag, out_llr, out_vld, e_llr, e_vld);
    end
  endtask

  // drive on a falling edge, result due after one rising edge, sample on next falling edge
  task automatic step(input string tag, input logic v, input logic g, input logic p,
                      input logic [MAG_W:0] a, input logic [MAG_W:0] b);
    in_vld = v; sel_g = g; psum = p; llr_a = a; llr_b = b;
    if (v) exp_llr = model(g, p, a, b);
    @(negedge clk);
    check(tag, exp_llr, v);
  endtask

  initial begin : watchdog
    repeat (WDOG) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    rst = 1'b1; in_vld = 1'b1; sel_g = 1'b1; psum = 1'b0;
    llr_a = 6'b000111; llr_b = 6'b000011;
    repeat (3) @(negedge clk);
    check("R1 reset", '0, 1'b0);
    rst = 1'b0;
    exp_llr = '0;

    // R2 f mode, sign combinations
    step("R2 f ++", 1, 0, 0, 6'b000101, 6'b001001);
    step("R2 f -+", 1, 0, 0, 6'b101100, 6'b000110);
    step("R2 f --", 1, 0, 1, 6'b111111, 6'b111110);
    step("R2 f +- max", 1, 0, 0, 6'b011111, 6'b111111);
    // R3 g mode
    step("R3 g add", 1, 1, 0, 6'b000101, 6'b001001);
    step("R3 g sub", 1, 1, 1, 6'b000101, 6'b000011);
    step("R3 g sub neg a", 1, 1, 1, 6'b100100, 6'b100111);
    // R4 saturation both directions
    step("R4 sat pos", 1, 1, 0, 6'b011111, 6'b011111);
    step("R4 sat neg", 1, 1, 0, 6'b111111, 6'b110000);
    step("R4 sat sub", 1, 1, 1, 6'b011111, 6'b111111);
    step("R4 edge", 1, 1, 0, 6'b010000, 6'b001111);
    // R5 negative zero inputs
    step("R5 f negzero", 1, 0, 0, 6'b100000, 6'b000111);
    step("R5 g negzero", 1, 1, 1, 6'b100000, 6'b100110);
    // R6 zero results positive
    step("R6 g cancel", 1, 1, 0, 6'b001010, 6'b101010);
    step("R6 f zero neg", 1, 0, 0, 6'b000000, 6'b110101);
    // R8 hold with changing inputs while invalid
    step("R7 load", 1, 1, 0, 6'b000011, 6'b000100);
    step("R8 hold", 0, 0, 1, 6'b111111, 6'b000001);
    step("R8 hold2", 0, 1, 0, 6'b011111, 6'b011111);
    step("R7 resume", 1, 0, 0, 6'b100010, 6'b000111);

    for (int i = 0; i < 3000; i++) begin
      logic v, g, p;
      logic [MAG_W:0] a, b;
      v = ($urandom_range(3) != 0);
      g = 1'($urandom);
      p = 1'($urandom);
      a = (MAG_W+1)'($urandom);
      b = (MAG_W+1)'($urandom);
      if (!v)      step("R8 rand hold", v, g, p, a, b);
      else if (g)  step("R3 R4 rand g", v, g, p, a, b);
      else         step("R2 rand f", v, g, p, a, b);
    end

    // R1 reset in the middle of traffic
    in_vld = 1'b1; sel_g = 1'b1; psum = 1'b0; llr_a = 6'b000101; llr_b = 6'b000101;
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset", '0, 1'b0);
    rst = 1'b0;
    exp_llr = '0;
    step("R7 after reset", 1, 1, 0, 6'b000101, 6'b000101);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule